// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block sits on the host side of an asynchronous 8-bit NAND flash bus. It takes one high-level request at a time from a valid/ready port and runs the whole bus transaction on its own. The request can be a page read, a block erase, an identifier read or a status read. The block drives chip enable, the command and address latch strobes, the write and read strobes, write-protect and the 8-bit output path. It polls the ready/busy line and returns every byte it reads as one beat on a response port. The response port has no back-pressure.

Every strobe phase is a whole number of system clocks, set by a parameter. A device that stays busy too long makes the block abort the request and return an error beat. A request carries an operation code (0 page read, 1 block erase, 2 identifier read, 3 status read), a 29-bit flash byte address and a count field. The count field selects how many bytes a page read or identifier read returns.

Top module: `nand_seq`

## Requirements
- R1: A page read issues command 00h, then five address cycles, then command 30h, then waits for ready, then performs count+1 data reads. The five address bytes are, in order: A[7:0], {4'b0,A[11:8]}, A[19:12], A[27:20], {7'b0,A[28]}.
- R2: A block erase issues command 60h, then three address cycles, then command D0h, then waits for ready, then issues command 70h and performs one data read. The three address bytes are {A[19:18],6'b0}, A[27:20] and {7'b0,A[28]}, so the page bits A[17:12] never reach the bus. The single response byte is the status byte, and rspFail equals its bit 0.
- R3: An identifier read issues command 90h, then one address cycle of 00h, then count+1 data reads, each returned as a response beat.
- R4: A status read issues command 70h and one data read. The byte is returned with rspFail low, whatever its bit 0 is.
- R5: Bus cycles are distinguished by strobes. The command strobe is high only on command cycles, the address strobe only on address cycles, and on a data read both are low and the output path is released. The output byte is already stable on the clock where the write strobe falls and is unchanged where it rises.
- R6: At least T_ADL clocks pass between the write-strobe rise of the last address cycle and the first read-strobe fall that follows it.
- R7: After a confirm command the block waits T_WB clocks and then polls ready/busy. No read strobe falls while ready/busy is low.
- R8: If ready/busy stays low for TIMEOUT polled clocks, the block issues one response beat with rspErr=1, rspLast=1 and data 00h. It then releases chip enable and accepts a new request.
- R9: reqReady is high only when no request is in progress. It goes low on the clock after acceptance and stays low until the final response beat has been issued. Chip enable is low exactly while a request is in progress.
- R10: Write-protect (active low) is driven high only while a block erase request is in progress and is low at all other times.
- R11: Each data read produces exactly one response beat. rspLast is set on the final beat only, and rspErr is low on all beats of a completed request.
- R12: After reset, reqReady is high, chip enable, write strobe and read strobe are high, the command and address strobes, write-protect, the output enable and rspValid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqOp | input | 2 | 0 page read, 1 block erase, 2 identifier read, 3 status read |
| reqAddr | input | 29 | Flash byte address |
| reqCount | input | CNT_W | Bytes to read minus one (page read and identifier read) |
| rspValid | output | 1 | Response beat valid |
| rspData | output | 8 | Byte read from the device |
| rspLast | output | 1 | Final beat of the request |
| rspErr | output | 1 | Busy wait timed out |
| rspFail | output | 1 | Erase reported failure (status bit 0) |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch strobe |
| nandAle | output | 1 | Address latch strobe |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandWpN | output | 1 | Write-protect, active low |
| nandRbN | input | 1 | Ready/busy, low while busy |
| nandDqOut | output | 8 | Byte driven onto the bus |
| nandDqOe | output | 1 | Output enable for nandDqOut |
| nandDqIn | input | 8 | Byte sampled from the bus |

## Verification
The hardest case to reach is the timeout abort. The device has to accept the whole command and address sequence and then never leave busy. The bench's flash model has a hang switch that holds ready/busy low after the confirm command. The bench checks the error beat, the release of the bus, and a normal request served afterwards. The address-to-data gap only appears on the identifier read, because every other address phase is followed by a command. The model timestamps the address-cycle write edge and the first read fall to measure that gap.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int ADDR_W = 29;

  typedef enum logic [1:0] {
    OP_READ = 2'd0, OP_ERASE = 2'd1, OP_ID = 2'd2, OP_STATUS = 2'd3
  } opE;

  typedef enum logic [2:0] {
    K_CMD = 3'd0, K_ADDR = 3'd1, K_GAP = 3'd2, K_BUSY = 3'd3, K_READ = 3'd4, K_END = 3'd5
  } kindE;

  typedef struct packed {
    kindE       kind;
    logic [7:0] val;   // opcode for K_CMD, address-byte selector for K_ADDR
  } stepT;

  typedef struct packed {
    logic       load;     // latch request fields
    logic       drive;    // latch next bus byte
    logic       isAddr;   // byte comes from address selector
    logic [7:0] val;
    logic       capture;  // sample bus into a response beat
    logic       abort;    // issue timeout beat
  } dpCtlT;

  localparam logic [7:0] OPC_PAGE_SET  = 8'h00;
  localparam logic [7:0] OPC_PAGE_GO   = 8'h30;
  localparam logic [7:0] OPC_ERASE_SET = 8'h60;
  localparam logic [7:0] OPC_ERASE_GO  = 8'hD0;
  localparam logic [7:0] OPC_IDENT     = 8'h90;
  localparam logic [7:0] OPC_STATUS    = 8'h70;
endpackage

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtlT             ctl,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  output opE                curOp,
  output logic              remZero,
  output logic [7:0]        dqOut,
  input  logic [7:0]        dqIn,
  output logic              rspValid,
  output logic [7:0]        rspData,
  output logic              rspLast,
  output logic              rspErr,
  output logic              rspFail
);
  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  remQ;
  logic [7:0]        addrByte;

  assign remZero = (remQ == '0);

  // address-cycle byte layout for x8 bus
  always_comb begin
    unique case (ctl.val[2:0])
      3'd0:    addrByte = addrQ[7:0];
      3'd1:    addrByte = {4'b0, addrQ[11:8]};
      3'd2:    addrByte = addrQ[19:12];
      3'd3:    addrByte = addrQ[27:20];
      3'd4:    addrByte = {7'b0, addrQ[28]};
      3'd5:    addrByte = {addrQ[19:18], 6'b0};  // erase row: page bits masked
      default: addrByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      remQ     <= '0;
      curOp    <= OP_READ;
      dqOut    <= 8'h00;
      rspValid <= 1'b0;
      rspData  <= 8'h00;
      rspLast  <= 1'b0;
      rspErr   <= 1'b0;
      rspFail  <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      if (ctl.load) begin
        curOp <= opE'(reqOp);
        addrQ <= reqAddr;
        remQ  <= (opE'(reqOp) == OP_READ || opE'(reqOp) == OP_ID) ? reqCount : '0;
      end
      if (ctl.drive) dqOut <= ctl.isAddr ? addrByte : ctl.val;
      if (ctl.capture) begin
        rspValid <= 1'b1;
        rspData  <= dqIn;
        rspLast  <= remZero;
        rspErr   <= 1'b0;
        rspFail  <= (curOp == OP_ERASE) & dqIn[0];
        remQ     <= remQ - 1'b1;
      end else if (ctl.abort) begin
        rspValid <= 1'b1;
        rspData  <= 8'h00;
        rspLast  <= 1'b1;
        rspErr   <= 1'b1;
        rspFail  <= 1'b0;
      end
    end
  end

  a_r8_err_is_last: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (rspLast && rspData == 8'h00));
  a_r11_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspLast) |=> !rspValid);
endmodule

// File: rtl/nand_seq_ctl.sv
module nand_seq_ctl
  import nand_seq_pkg::*;
#(
  parameter int T_SETUP = 1,
  parameter int T_WP    = 3,
  parameter int T_HOLD  = 1,
  parameter int T_RP    = 3,
  parameter int T_REH   = 2,
  parameter int T_ADL   = 5,
  parameter int T_WB    = 5,
  parameter int TIMEOUT = 50000
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqValid,
  output logic  reqReady,
  input  opE    curOp,
  input  logic  remZero,
  input  logic  rbN,
  output dpCtlT ctl,
  output logic  ceN,
  output logic  cle,
  output logic  ale,
  output logic  weN,
  output logic  reN,
  output logic  wpN,
  output logic  dqOe
);
  localparam int T_SUM = T_SETUP + T_WP + T_HOLD + T_RP + T_REH + T_ADL + T_WB;
  localparam int TMR_W = $clog2(T_SUM + 1);
  localparam int TO_W  = $clog2(TIMEOUT + 1);
  localparam int ADL_W = $clog2(T_ADL + 2) + 1;
  localparam logic [TMR_W-1:0] L_SETUP = TMR_W'(T_SETUP - 1);
  localparam logic [TMR_W-1:0] L_WP    = TMR_W'(T_WP - 1);
  localparam logic [TMR_W-1:0] L_HOLD  = TMR_W'(T_HOLD - 1);
  localparam logic [TMR_W-1:0] L_RP    = TMR_W'(T_RP - 1);
  localparam logic [TMR_W-1:0] L_REH   = TMR_W'(T_REH - 1);
  localparam logic [TMR_W-1:0] L_ADL   = TMR_W'(T_ADL - 1);
  localparam logic [TMR_W-1:0] L_WB    = TMR_W'(T_WB - 1);
  localparam logic [TO_W-1:0]  TO_LAST = TO_W'(TIMEOUT - 1);

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_SET, S_LOW, S_HIGH, S_GAP, S_WB, S_BUSY} stateE;

  stateE            state;
  kindE             kindQ;
  logic [3:0]       idx;
  logic [TMR_W-1:0] tmr;
  logic [TO_W-1:0]  toCnt;
  logic             moreRd;
  stepT             step;
  logic             wrKind, wrPhase;

  function automatic stepT stepOf(opE op, logic [3:0] i);
    stepT s;
    s = '{K_END, 8'h00};
    case (op)
      OP_READ: case (i)
        4'd0: s = '{K_CMD, OPC_PAGE_SET};
        4'd1, 4'd2, 4'd3, 4'd4, 4'd5: s = '{K_ADDR, 8'(i - 4'd1)};
        4'd6: s = '{K_CMD, OPC_PAGE_GO};
        4'd7: s = '{K_BUSY, 8'h00};
        4'd8: s = '{K_READ, 8'h00};
        default: s = '{K_END, 8'h00};
      endcase
      OP_ERASE: case (i)
        4'd0: s = '{K_CMD, OPC_ERASE_SET};
        4'd1: s = '{K_ADDR, 8'd5};
        4'd2: s = '{K_ADDR, 8'd3};
        4'd3: s = '{K_ADDR, 8'd4};
        4'd4: s = '{K_CMD, OPC_ERASE_GO};
        4'd5: s = '{K_BUSY, 8'h00};
        4'd6: s = '{K_CMD, OPC_STATUS};
        4'd7: s = '{K_READ, 8'h00};
        default: s = '{K_END, 8'h00};
      endcase
      OP_ID: case (i)
        4'd0: s = '{K_CMD, OPC_IDENT};
        4'd1: s = '{K_ADDR, 8'd6};
        4'd2: s = '{K_GAP, 8'h00};
        4'd3: s = '{K_READ, 8'h00};
        default: s = '{K_END, 8'h00};
      endcase
      default: case (i)
        4'd0: s = '{K_CMD, OPC_STATUS};
        4'd1: s = '{K_READ, 8'h00};
        default: s = '{K_END, 8'h00};
      endcase
    endcase
    return s;
  endfunction

  assign step = stepOf(curOp, idx);

  always_comb begin
    ctl         = '0;
    ctl.val     = step.val;
    ctl.isAddr  = (step.kind == K_ADDR);
    ctl.load    = (state == S_IDLE) && reqValid;
    ctl.drive   = (state == S_STEP) && (step.kind == K_CMD || step.kind == K_ADDR);
    ctl.capture = (state == S_LOW) && (kindQ == K_READ) && (tmr == '0);
    ctl.abort   = (state == S_BUSY) && !rbN && (toCnt == TO_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      kindQ  <= K_END;
      idx    <= '0;
      tmr    <= '0;
      toCnt  <= '0;
      moreRd <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (reqValid) begin
          state <= S_STEP;
          idx   <= '0;
        end
        S_STEP: begin
          kindQ <= step.kind;
          unique case (step.kind)
            K_CMD, K_ADDR: begin state <= S_SET; tmr <= L_SETUP; end
            K_READ:        begin state <= S_LOW; tmr <= L_RP; end
            K_GAP:         begin state <= S_GAP; tmr <= L_ADL; end
            K_BUSY:        begin state <= S_WB;  tmr <= L_WB; toCnt <= '0; end
            default:       state <= S_IDLE;
          endcase
        end
        S_SET: if (tmr == '0) begin state <= S_LOW; tmr <= L_WP; end
               else tmr <= tmr - 1'b1;
        S_LOW: if (tmr == '0) begin
          state <= S_HIGH;
          if (kindQ == K_READ) begin
            moreRd <= !remZero;
            tmr    <= L_REH;
          end else tmr <= L_HOLD;
        end else tmr <= tmr - 1'b1;
        S_HIGH: if (tmr == '0) begin
          if (kindQ == K_READ && moreRd) begin state <= S_LOW; tmr <= L_RP; end
          else begin state <= S_STEP; idx <= idx + 1'b1; end
        end else tmr <= tmr - 1'b1;
        S_GAP: if (tmr == '0) begin state <= S_STEP; idx <= idx + 1'b1; end
               else tmr <= tmr - 1'b1;
        S_WB: if (tmr == '0) state <= S_BUSY;
              else tmr <= tmr - 1'b1;
        S_BUSY: if (rbN) begin state <= S_STEP; idx <= idx + 1'b1; end
                else if (toCnt == TO_LAST) state <= S_IDLE;
                else toCnt <= toCnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign wrKind   = (kindQ == K_CMD) || (kindQ == K_ADDR);
  assign wrPhase  = wrKind && (state == S_SET || state == S_LOW || state == S_HIGH);
  assign reqReady = (state == S_IDLE);
  assign ceN      = (state == S_IDLE);
  assign cle      = wrPhase && (kindQ == K_CMD);
  assign ale      = wrPhase && (kindQ == K_ADDR);
  assign dqOe     = wrPhase;
  assign weN      = !((state == S_LOW) && wrKind);
  assign reN      = !((state == S_LOW) && (kindQ == K_READ));
  assign wpN      = (state != S_IDLE) && (curOp == OP_ERASE);

  // gap tracker for the address-to-data check
  logic             weNQ, reNQ, adlArm;
  logic [ADL_W-1:0] adlCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weNQ <= 1'b1; reNQ <= 1'b1; adlArm <= 1'b0; adlCnt <= '0;
    end else begin
      weNQ <= weN;
      reNQ <= reN;
      if (!weNQ && weN && ale) begin adlArm <= 1'b1; adlCnt <= '0; end
      else begin
        if (!weNQ && weN && cle) adlArm <= 1'b0;
        if (adlCnt != '1) adlCnt <= adlCnt + 1'b1;
      end
    end
  end

  a_r6_adl_gap: assert property (@(posedge clk) disable iff (!rstN)
    (reNQ && !reN && adlArm) |-> (int'(adlCnt) + 1 >= T_ADL));
  a_r7_no_read_busy: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> rbN);
  a_r9_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqReady && !ceN));
  a_r10_wp_in_req: assert property (@(posedge clk) disable iff (!rstN)
    wpN |-> !ceN);
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int T_SETUP = 1,
  parameter int T_WP    = 3,
  parameter int T_HOLD  = 1,
  parameter int T_RP    = 3,
  parameter int T_REH   = 2,
  parameter int T_ADL   = 5,
  parameter int T_WB    = 5,
  parameter int TIMEOUT = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  output logic              rspValid,
  output logic [7:0]        rspData,
  output logic              rspLast,
  output logic              rspErr,
  output logic              rspFail,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic              nandWpN,
  input  logic              nandRbN,
  output logic [7:0]        nandDqOut,
  output logic              nandDqOe,
  input  logic [7:0]        nandDqIn
);
  dpCtlT ctlW;
  opE    curOp;
  logic  remZero;

  nand_seq_ctl #(
    .T_SETUP(T_SETUP), .T_WP(T_WP), .T_HOLD(T_HOLD), .T_RP(T_RP),
    .T_REH(T_REH), .T_ADL(T_ADL), .T_WB(T_WB), .TIMEOUT(TIMEOUT)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .curOp(curOp), .remZero(remZero), .rbN(nandRbN), .ctl(ctlW),
    .ceN(nandCeN), .cle(nandCle), .ale(nandAle), .weN(nandWeN),
    .reN(nandReN), .wpN(nandWpN), .dqOe(nandDqOe)
  );

  nand_seq_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctlW), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqCount(reqCount), .curOp(curOp), .remZero(remZero), .dqOut(nandDqOut),
    .dqIn(nandDqIn), .rspValid(rspValid), .rspData(rspData), .rspLast(rspLast),
    .rspErr(rspErr), .rspFail(rspFail)
  );

  a_r5_we_fall_stable: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandWeN) |-> ($stable(nandDqOut) && nandDqOe));
  a_r5_we_rise_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> ($stable(nandDqOut) && (nandCle || nandAle)));
  a_r5_read_released: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> (!nandCle && !nandAle && !nandDqOe));
endmodule

// File: tb/nand_seq_tb.sv
module nand_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_ADL_TB   = 6;
  localparam int TIMEOUT_TB = 100;
  localparam int BUSY_CYC   = 15;
  localparam int WD_LIMIT   = 100000;

  typedef struct packed {
    logic [1:0]  op;
    logic [28:0] addr;
    logic [11:0] cnt;
    logic [7:0]  stat;
  } vecT;

  localparam vecT VEC [7] = '{
    '{2'd0, 29'h1ABCD123, 12'd3, 8'hE0},
    '{2'd0, 29'h00000FFF, 12'd0, 8'hE0},
    '{2'd1, 29'h1FFFFFFF, 12'd0, 8'hE0},
    '{2'd1, 29'h0003F000, 12'd9, 8'hE1},
    '{2'd2, 29'h00000000, 12'd3, 8'hE0},
    '{2'd3, 29'h00000000, 12'd0, 8'h61},
    '{2'd0, 29'h0F0F5A5A, 12'd7, 8'hE0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [1:0] reqOp = 2'd0;
  logic [28:0] reqAddr = '0;
  logic [11:0] reqCount = '0;
  logic rspValid, rspLast, rspErr, rspFail;
  logic [7:0] rspData;
  logic ceN, cle, ale, weN, reN, wpN, dqOe;
  logic rbN = 1'b1;
  logic [7:0] dqOut;
  logic [7:0] dqIn = 8'h00;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nand_seq #(
    .CNT_W(12), .T_SETUP(1), .T_WP(2), .T_HOLD(1), .T_RP(2), .T_REH(1),
    .T_ADL(T_ADL_TB), .T_WB(2), .TIMEOUT(TIMEOUT_TB)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqCount(reqCount),
    .rspValid(rspValid), .rspData(rspData), .rspLast(rspLast),
    .rspErr(rspErr), .rspFail(rspFail), .nandCeN(ceN), .nandCle(cle),
    .nandAle(ale), .nandWeN(weN), .nandReN(reN), .nandWpN(wpN),
    .nandRbN(rbN), .nandDqOut(dqOut), .nandDqOe(dqOe), .nandDqIn(dqIn)
  );

  int checks = 0, failures = 0, cyc = 0;

  // flash model and observers
  logic [9:0] busLog [32];
  int   logN = 0;
  logic [7:0] rspD [32];
  logic rspL [32], rspE [32], rspF [32];
  int   rspN = 0;
  int   mode = 0, ptr = 0, addrIdx = 0, busyLeft = 0;
  logic [7:0] rowLo = 8'h00, devStat = 8'hE0;
  logic hang = 1'b0, prevWe = 1'b1, prevRe = 1'b1, aleArm = 1'b0, wpSeen = 1'b0;
  int   lastAle = 0, gapMin = 9999, reBusy = 0, reFalls = 0;

  function automatic logic [7:0] idByte(int k);
    case (k)
      0: return 8'hAD;
      1: return 8'hF1;
      2: return 8'h80;
      3: return 8'h15;
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!ceN) begin
      if (!prevWe && weN) begin
        busLog[logN[4:0]] = {cle, ale, dqOut};
        logN = logN + 1;
        if (cle) begin
          ptr = 0; addrIdx = 0; aleArm = 1'b0;
          if (dqOut == 8'h00 || dqOut == 8'h30) mode = 0;
          if (dqOut == 8'h90) mode = 1;
          if (dqOut == 8'h70) mode = 2;
          if (dqOut == 8'h30 || dqOut == 8'hD0) busyLeft = BUSY_CYC;
        end else if (ale) begin
          if (addrIdx == 2) rowLo = dqOut;
          addrIdx = addrIdx + 1;
          lastAle = cyc; aleArm = 1'b1;
        end
      end
      if (prevRe && !reN) begin
        reFalls = reFalls + 1;
        if (!rbN) reBusy = reBusy + 1;
        if (aleArm) begin
          if (cyc - lastAle < gapMin) gapMin = cyc - lastAle;
          aleArm = 1'b0;
        end
        if (mode == 0) dqIn = 8'h3C ^ ptr[7:0] ^ rowLo;
        else if (mode == 1) dqIn = idByte(ptr);
        else dqIn = devStat;
        ptr = ptr + 1;
      end
      if (wpN) wpSeen = 1'b1;
    end
    if (rspValid) begin
      rspD[rspN[4:0]] = rspData; rspL[rspN[4:0]] = rspLast;
      rspE[rspN[4:0]] = rspErr;  rspF[rspN[4:0]] = rspFail;
      rspN = rspN + 1;
    end
    if (busyLeft > 0) busyLeft = busyLeft - 1;
    rbN = !(hang || busyLeft > 0);
    prevWe = weN; prevRe = reN;
    if (cyc == WD_LIMIT) begin
      checks = checks + 1; failures = failures + 1;
      $display("FAIL watchdog expired act=%0d exp=<%0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  logic [9:0] expBus [16];
  int expN;
  task automatic push(input logic [9:0] e);
    expBus[expN] = e; expN = expN + 1;
  endtask

  task automatic buildExp(input logic [1:0] op, input logic [28:0] a);
    expN = 0;
    case (op)
      2'd0: begin
        push({2'b10, 8'h00}); push({2'b01, a[7:0]}); push({2'b01, 4'h0, a[11:8]});
        push({2'b01, a[19:12]}); push({2'b01, a[27:20]}); push({2'b01, 7'h0, a[28]});
        push({2'b10, 8'h30});
      end
      2'd1: begin
        push({2'b10, 8'h60}); push({2'b01, a[19:18], 6'h0}); push({2'b01, a[27:20]});
        push({2'b01, 7'h0, a[28]}); push({2'b10, 8'hD0}); push({2'b10, 8'h70});
      end
      2'd2: begin push({2'b10, 8'h90}); push({2'b01, 8'h00}); end
      default: push({2'b10, 8'h70});
    endcase
  endtask

  task automatic runReq(input logic [1:0] op, input logic [28:0] a, input logic [11:0] n);
    logN = 0; rspN = 0; gapMin = 9999; reBusy = 0; reFalls = 0; wpSeen = 1'b0;
    reqOp = op; reqAddr = a; reqCount = n; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady && !ceN, "R9 ready low and CE asserted after accept", {reqReady, ceN}, 0);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady && ceN && weN && reN && !cle && !ale && !wpN && !dqOe && !rspValid,
        "R12 reset state", {reqReady, ceN, weN, reN, cle, ale, wpN, dqOe, rspValid}, 9'b111100000);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && ceN && wpN == 1'b0, "R12 idle after reset", {reqReady, ceN, wpN}, 3'b110);

    foreach (VEC[v]) begin
      int expRsp;
      devStat = VEC[v].stat;
      buildExp(VEC[v].op, VEC[v].addr);
      runReq(VEC[v].op, VEC[v].addr, VEC[v].cnt);
      chk(logN == expN, "R1-R4 bus write count", logN, expN);
      for (int i = 0; i < expN && i < logN; i++)
        chk(busLog[i] == expBus[i], "R1 R2 R3 R4 R5 bus cycle", busLog[i], expBus[i]);
      expRsp = (VEC[v].op == 2'd0 || VEC[v].op == 2'd2) ? int'(VEC[v].cnt) + 1 : 1;
      chk(rspN == expRsp, "R11 response beat count", rspN, expRsp);
      for (int k = 0; k < expRsp && k < rspN; k++) begin
        logic [7:0] eb;
        case (VEC[v].op)
          2'd0: eb = 8'h3C ^ k[7:0] ^ VEC[v].addr[19:12];
          2'd2: eb = idByte(k);
          default: eb = VEC[v].stat;
        endcase
        chk(rspD[k] == eb, "R1 R2 R3 R4 response byte", rspD[k], eb);
        chk(rspL[k] == (k == expRsp - 1) && !rspE[k], "R11 last flag and no error",
            {rspL[k], rspE[k]}, {(k == expRsp - 1), 1'b0});
        chk(rspF[k] == (VEC[v].op == 2'd1 && VEC[v].stat[0]), "R2 R4 fail flag",
            rspF[k], (VEC[v].op == 2'd1 && VEC[v].stat[0]));
      end
      chk(wpSeen == (VEC[v].op == 2'd1), "R10 write-protect release", wpSeen, (VEC[v].op == 2'd1));
      chk(reBusy == 0, "R7 no read strobe while busy", reBusy, 0);
      if (VEC[v].op == 2'd2)
        chk(gapMin >= T_ADL_TB, "R6 address-to-data gap", gapMin, T_ADL_TB);
      chk(ceN && wpN == 1'b0, "R9 R10 bus released at end", {ceN, wpN}, 2'b10);
    end

    // timeout: device never leaves busy
    hang = 1'b1;
    runReq(2'd0, 29'h00123456, 12'd2);
    chk(rspN == 1, "R8 single timeout beat", rspN, 1);
    chk(rspE[0] && rspL[0] && rspD[0] == 8'h00, "R8 timeout beat content",
        {rspE[0], rspL[0], rspD[0]}, {2'b11, 8'h00});
    chk(reFalls == 0, "R8 R7 no data read after timeout", reFalls, 0);
    chk(logN == 7, "R8 commands issued before busy", logN, 7);
    chk(ceN && reqReady, "R8 R9 released and ready", {ceN, reqReady}, 2'b11);
    hang = 1'b0;
    @(negedge clk);

    // recovery: status read works after abort
    devStat = 8'hC0;
    runReq(2'd3, 29'h0, 12'd0);
    chk(rspN == 1 && rspD[0] == 8'hC0 && !rspE[0] && rspL[0], "R4 R8 status after timeout",
        {rspN[7:0], rspD[0]}, {8'd1, 8'hC0});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule